// File: doc/BRIEF.md
# Dual-Width Integer ALU

This block executes the arithmetic operations of a small register-machine instruction set on one 64-bit destination value and one source operand. The source operand comes either from a second 64-bit register value or from a 32-bit immediate. Each operation runs in either a full 64-bit mode or a 32-bit mode. The 32-bit mode works on the low halves and always clears the upper half of the result. The block also performs byte-order conversion at 16, 32 or 64 bits, with the width taken from the immediate.

The surrounding pipeline decodes the instruction and reads the register file. It then presents the operands, the 4-bit operation code, the source-select bit and the width-mode bit with `in_valid`. One cycle later the block returns the result and a write enable that tells the pipeline whether the destination register must be written. The block raises no carry, sign or overflow indication. Any overflow wraps inside the selected width. A parameter removes the output register, which makes the block purely combinational.

Top module: `dual_width_alu`

## Requirements
- R1: With `wide_mode`=1, these operation codes produce a 64-bit result that wraps on overflow: 0x0 add, 0x1 subtract, 0x2 multiply (low 64 bits), 0x4 OR, 0x5 AND, 0x8 negate (two's complement of the destination), 0xA XOR and 0xB move (source operand).
- R2: With `wide_mode`=0, every operation except byte swap and modulo-by-zero uses only bits 31:0 of the destination and of the source operand. The result wraps at 32 bits, and result bits 63:32 are zero.
- R3: `src_is_reg`=1 selects `src_val` as the source operand. `src_is_reg`=0 selects `imm_val` sign-extended to 64 bits, and in 32-bit mode only its low 32 bits are used.
- R4: Modulo (code 0x9) with a source operand of zero, measured in the selected width, writes back the full 64-bit destination value unchanged.
- R5: Division (code 0x3) by a source operand of zero yields zero.
- R6: Division (0x3) and modulo (0x9) treat both operands as unsigned. This holds for a sign-extended immediate too, so an immediate of -1 acts as the largest unsigned value.
- R7: Shift left (0x6), logical shift right (0x7) and arithmetic shift right (0xC) use only the low 6 bits of the source operand as the shift count in 64-bit mode, and only the low 5 bits in 32-bit mode.
- R8: Code 0xC shifts right and fills with copies of the sign bit. The sign bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode, and in 32-bit mode the result is then zero-extended.
- R9: Code 0xD converts byte order over the width given by `imm_val` (16, 32 or 64), regardless of `wide_mode`. With `src_is_reg`=0 the low width bits of the destination pass through and the rest is zero-filled. With `src_is_reg`=1 the bytes within that width are reversed and the rest is zero-filled.
- R10: Code 0xD with any `imm_val` other than 16, 32 or 64 gives `wr_en`=0.
- R11: When `in_valid` is low, or the code is 0xE or 0xF, `wr_en` is 0. Whenever `wr_en` is 0, `result` is zero.
- R12: During and straight after synchronous active-low reset, `wr_en` is 0 and `result` is zero.
- R13: With the output register present (default), `wr_en` and `result` for an operation appear on the rising edge that follows the cycle `in_valid` was presented. A new operation is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation code |
| src_is_reg | input | 1 | 1: register source; 0: immediate source. For byte swap: 1 big-endian, 0 little-endian |
| wide_mode | input | 1 | 1: 64-bit mode; 0: 32-bit mode |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate; for byte swap, the width |
| wr_en | output | 1 | Destination write enable |
| result | output | 64 | Value to write back |

## Verification
Every result, including the write enable, is due on the first rising edge after its operands were presented. The block makes no exception for division, byte swap or the rejected cases, and back-to-back operations each keep that one-cycle spacing. The bench drives one operation or idle slot per falling edge and pushes the expected write enable and value for each slot into a queue. A monitor pops one entry a nanosecond after every rising edge, so each comparison lands exactly one register stage behind its stimulus. Corner values such as wrap at both widths, zero divisors, negative immediates, shift counts above the width and invalid swap widths each get their own slot.

// File: rtl/dwalu_pkg.sv
// Package: shared operation codes and constants of the dual-width ALU.
// Assumes operation codes occupy four bits; 0xE and 0xF are unassigned.
package dwalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_SRA  = 4'hC,
        OP_SWAP = 4'hD
    } alu_op_e;

    localparam int unsigned BYTE_W = 8;

    // True for every assigned operation code
    function automatic logic op_is_legal(input logic [3:0] code);
        return code <= 4'hD;
    endfunction

endpackage

// File: rtl/dwalu_operands.sv
// Module: forms the two operands seen by the arithmetic unit.
// The second operand is the register source or the sign-extended immediate.
// In 32-bit mode both operands are cut to their low half and zero-extended.
// Assumes IMM_W is at least DATA_W/2 and below DATA_W.
module dwalu_operands #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              src_is_reg,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_raw;

    // Select the source and narrow both operands to the active width
    always_comb begin
        imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        b_raw   = src_is_reg ? src_val : imm_ext;
        if (wide_mode) begin
            opnd_a = dst_val;
            opnd_b = b_raw;
        end else begin
            opnd_a = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
            opnd_b = {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/dwalu_arith.sv
// Module: integer arithmetic, logic and shift datapath of the ALU.
// Operands arrive already narrowed for 32-bit mode; the result is cut back
// to the active width. Division and modulo are unsigned; division by zero
// gives zero, and modulo by zero raises keep_dst so the top writes back the
// destination unchanged. Byte swap is handled elsewhere.
module dwalu_arith
    import dwalu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op_code,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] arith_res,
    output logic              keep_dst
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [SH_W-1:0]   sh_amt;
    logic              divisor_zero;
    logic [DATA_W-1:0] sra_wide;
    logic [HALF_W-1:0] sra_narrow;
    logic [DATA_W-1:0] raw;

    // Shift count masked to the active width, and zero-divisor detection
    always_comb begin
        sh_amt       = wide_mode ? opnd_b[SH_W-1:0] : {1'b0, opnd_b[SH_W-2:0]};
        divisor_zero = (opnd_b == '0);
        sra_wide     = DATA_W'($signed(opnd_a) >>> sh_amt);
        sra_narrow   = HALF_W'($signed(opnd_a[HALF_W-1:0]) >>> sh_amt);
    end

    // Operation select and narrowing of the result
    always_comb begin
        keep_dst = 1'b0;
        unique case (alu_op_e'(op_code))
            OP_ADD:  raw = opnd_a + opnd_b;
            OP_SUB:  raw = opnd_a - opnd_b;
            OP_MUL:  raw = opnd_a * opnd_b;
            OP_DIV:  raw = divisor_zero ? '0 : opnd_a / opnd_b;
            OP_OR:   raw = opnd_a | opnd_b;
            OP_AND:  raw = opnd_a & opnd_b;
            OP_SHL:  raw = opnd_a << sh_amt;
            OP_SHR:  raw = opnd_a >> sh_amt;
            OP_NEG:  raw = -opnd_a;
            OP_MOD: begin
                raw      = divisor_zero ? '0 : opnd_a % opnd_b;
                keep_dst = divisor_zero;
            end
            OP_XOR:  raw = opnd_a ^ opnd_b;
            OP_MOV:  raw = opnd_b;
            OP_SRA:  raw = wide_mode ? sra_wide : {{HALF_W{1'b0}}, sra_narrow};
            default: raw = '0;
        endcase
        arith_res = wide_mode ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end

endmodule

// File: rtl/dwalu_byteswap.sv
// Module: byte-order conversion over a width chosen by the immediate.
// Supported widths are the powers of two from 16 bits up to DATA_W.
// to_big=0 keeps the low bytes in place; to_big=1 reverses them. Bits above
// the width are zero. width_ok is low when the immediate names no width.
module dwalu_byteswap
    import dwalu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IMM_W-1:0]  width_sel,
    input  logic              to_big,
    output logic [DATA_W-1:0] dout,
    output logic              width_ok
);
    localparam int N_LVL = $clog2(DATA_W / BYTE_W);

    logic [DATA_W-1:0] cand [N_LVL];

    // One candidate per supported width: bytes reversed or passed through
    for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
        localparam int LW = BYTE_W << (k + 1);
        localparam int NB = LW / BYTE_W;
        logic [LW-1:0] rev;
        logic [LW-1:0] pick;
        for (genvar i = 0; i < NB; i++) begin : g_byte
            assign rev[i*BYTE_W +: BYTE_W] = din[(NB-1-i)*BYTE_W +: BYTE_W];
        end
        assign pick = to_big ? rev : din[LW-1:0];
        if (LW == DATA_W) begin : g_full
            assign cand[k] = pick;
        end else begin : g_part
            assign cand[k] = {{(DATA_W-LW){1'b0}}, pick};
        end
    end

    // Pick the candidate whose width matches the immediate
    always_comb begin
        dout     = '0;
        width_ok = 1'b0;
        for (int k = 0; k < N_LVL; k++) begin
            if (width_sel == IMM_W'(BYTE_W << (k + 1))) begin
                dout     = cand[k];
                width_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_width_alu.sv
// Module: top of the dual-width integer ALU.
// Combines operand forming, arithmetic and byte swap, decides the write
// enable and optionally registers the outputs (OUT_REG=1: one cycle of
// latency). Result is forced to zero whenever no write is requested.
// Assumes a synchronous active-low reset and IMM_W >= DATA_W/2.
module dual_width_alu
    import dwalu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic              src_is_reg,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              wr_en,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] opnd_a, opnd_b;
    logic [DATA_W-1:0] arith_res, swap_res;
    logic              keep_dst, width_ok;
    logic              is_swap, nxt_we;
    logic [DATA_W-1:0] nxt_res;

    dwalu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operands (
        .src_is_reg (src_is_reg),
        .wide_mode  (wide_mode),
        .dst_val    (dst_val),
        .src_val    (src_val),
        .imm_val    (imm_val),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    dwalu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_code    (op_code),
        .wide_mode  (wide_mode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .arith_res  (arith_res),
        .keep_dst   (keep_dst)
    );

    dwalu_byteswap #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_swap (
        .din        (dst_val),
        .width_sel  (imm_val),
        .to_big     (src_is_reg),
        .dout       (swap_res),
        .width_ok   (width_ok)
    );

    // Write-enable decision and result mux
    always_comb begin
        is_swap = (op_code == OP_SWAP);
        nxt_we  = in_valid && op_is_legal(op_code) && (!is_swap || width_ok);
        if (!nxt_we)       nxt_res = '0;
        else if (is_swap)  nxt_res = swap_res;
        else if (keep_dst) nxt_res = dst_val;
        else               nxt_res = arith_res;
    end

    if (OUT_REG) begin : g_reg
        // Output register with synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_en  <= 1'b0;
                result <= '0;
            end else begin
                wr_en  <= nxt_we;
                result <= nxt_res;
            end
        end

        // Zero divisor as seen at the ports, in the active width
        logic chk_div_zero;
        always_comb begin
            if (src_is_reg)
                chk_div_zero = wide_mode ? (src_val == '0) : (src_val[HALF_W-1:0] == '0);
            else
                chk_div_zero = wide_mode ? (imm_val == '0) : (imm_val[HALF_W-1:0] == '0);
        end

        p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !wide_mode && op_code <= 4'hC && op_code != 4'h9)
            |=> (result[DATA_W-1:HALF_W] == '0));

        p_keep_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_code == 4'h9 && chk_div_zero)
            |=> (wr_en && result == $past(dst_val)));

        p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_code == 4'h3 && chk_div_zero)
            |=> (wr_en && result == '0));

        p_swap_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_code == 4'hD && imm_val != IMM_W'(16)
             && imm_val != IMM_W'(32) && imm_val != IMM_W'(64))
            |=> !wr_en);

        p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_valid || op_code > 4'hD) |=> (!wr_en && result == '0));

        p_quiet_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |-> (result == '0));
    end else begin : g_comb
        assign wr_en  = nxt_we;
        assign result = nxt_res;
    end

endmodule

// File: tb/dual_width_alu_tb.sv
module dual_width_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        src_is_reg = 1'b0;
    logic        wide_mode = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic        wr_en;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit stim_done = 1'b0;

    logic        q_we  [$];
    logic [63:0] q_res [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    dual_width_alu u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_code    (op_code),
        .src_is_reg (src_is_reg),
        .wide_mode  (wide_mode),
        .dst_val    (dst_val),
        .src_val    (src_val),
        .imm_val    (imm_val),
        .wr_en      (wr_en),
        .result     (result)
    );

    // Reference model written from the requirements; returns {write, value}
    function automatic logic [64:0] model(input logic [3:0] op, input logic wide,
                                          input logic isreg, input logic [63:0] d,
                                          input logic [63:0] s, input logic [31:0] im);
        logic [63:0] bsel, a, b, r;
        int sh, w;
        bsel = isreg ? s : {{32{im[31]}}, im};
        if (wide) begin a = d; b = bsel; sh = int'(b[5:0]); end
        else begin a = {32'h0, d[31:0]}; b = {32'h0, bsel[31:0]}; sh = int'(b[4:0]); end
        r = '0;
        case (op)
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: r = (b == 0) ? 64'h0 : a / b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a << sh;
            4'h7: r = a >> sh;
            4'h8: r = 64'h0 - a;
            4'h9: begin
                if (b == 0) return {1'b1, d};
                r = a % b;
            end
            4'hA: r = a ^ b;
            4'hB: r = b;
            4'hC: r = wide ? 64'($signed(a) >>> sh) : {32'h0, 32'($signed(a[31:0]) >>> sh)};
            4'hD: begin
                w = int'(im);
                if (w != 16 && w != 32 && w != 64) return 65'h0;
                for (int i = 0; i < w / 8; i++)
                    r[8*i +: 8] = isreg ? d[8*(w/8-1-i) +: 8] : d[8*i +: 8];
                return {1'b1, r};
            end
            default: return 65'h0;
        endcase
        if (!wide) r[63:32] = 32'h0;
        return {1'b1, r};
    endfunction

    // Driver: present one operation at a falling edge, queue its expectation
    task automatic drive(input logic [3:0] op, input logic wide, input logic isreg,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input string tag);
        logic [64:0] e;
        @(negedge clk);
        in_valid = 1'b1; op_code = op; wide_mode = wide; src_is_reg = isreg;
        dst_val = d; src_val = s; imm_val = im;
        e = model(op, wide, isreg, d, s, im);
        q_we.push_back(e[64]); q_res.push_back(e[63:0]); q_tag.push_back(tag);
    endtask

    // Driver: an idle slot with junk on the operand inputs
    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; op_code = 4'h0; wide_mode = 1'b1; src_is_reg = 1'b1;
        dst_val = 64'hDEAD_BEEF_0BAD_F00D; src_val = 64'h1; imm_val = 32'h5;
        q_we.push_back(1'b0); q_res.push_back(64'h0); q_tag.push_back(tag);
    endtask

    // Monitor: one expectation retired just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_we.size() > 0) begin
                logic        ew;
                logic [63:0] er;
                string       et;
                ew = q_we.pop_front(); er = q_res.pop_front(); et = q_tag.pop_front();
                total++;
                if (wr_en !== ew || result !== er) begin
                    bad++;
                    $display("FAIL %s: wr_en=%0b result=%h expected wr_en=%0b result=%h",
                             et, wr_en, result, ew, er);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !stim_done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        in_valid = 1'b1; op_code = 4'h0; wide_mode = 1'b1; dst_val = 64'h5; src_is_reg = 1'b0; imm_val = 32'h3;
        @(posedge clk); #1;
        total++;
        if (wr_en !== 1'b0 || result !== 64'h0) begin
            bad++;
            $display("FAIL R12: wr_en=%0b result=%h expected wr_en=0 result=0", wr_en, result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // R1: 64-bit operations with wrap
        drive(4'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, "R1 add wrap");
        drive(4'h1, 1, 1, 64'h0, 64'h1, 0, "R1 sub wrap");
        drive(4'h2, 1, 1, 64'h1_0000_0001, 64'h1_0000_0003, 0, "R1 mul");
        drive(4'h4, 1, 0, 64'hF0, 64'h0, 32'h0F, "R1 or");
        drive(4'h5, 1, 1, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 0, "R1 and");
        drive(4'h8, 1, 1, 64'h5, 64'h0, 0, "R1 neg");
        drive(4'hA, 1, 1, 64'hAAAA_5555_AAAA_5555, 64'hFFFF_FFFF_0000_0000, 0, "R1 xor R13 back-to-back");
        drive(4'hB, 1, 1, 64'h0, 64'h1234_5678_9ABC_DEF0, 0, "R1 mov");
        // R2: 32-bit mode
        drive(4'h0, 0, 1, 64'h1_FFFF_FFFF, 64'h5_0000_0001, 0, "R2 add32 wrap");
        drive(4'h1, 0, 1, 64'hFFFF_0000_0000_0000, 64'h1, 0, "R2 sub32");
        drive(4'h2, 0, 1, 64'h0000_0001_8000_0000, 64'h3, 0, "R2 mul32");
        drive(4'h8, 0, 1, 64'h7777_0000_0000_0001, 64'h0, 0, "R2 neg32");
        // R3: source select and immediate sign extension
        drive(4'hB, 1, 0, 64'h0, 64'h1111, 32'hFFFF_FFFF, "R3 mov imm 64");
        drive(4'hB, 0, 0, 64'h0, 64'h1111, 32'hFFFF_FFFF, "R3 mov imm 32");
        drive(4'h0, 1, 0, 64'h10, 64'h9999, 32'hFFFF_FFFE, "R3 add neg imm");
        drive(4'h0, 1, 1, 64'h10, 64'h9999, 32'hFFFF_FFFE, "R3 add reg");
        // R4: modulo by zero
        drive(4'h9, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h0, 0, "R4 mod zero 64");
        drive(4'h9, 0, 1, 64'hABCD_0000_1234_0000, 64'h1_0000_0000, 0, "R4 mod zero 32");
        drive(4'h9, 1, 0, 64'h77, 64'h5, 32'h0, "R4 mod zero imm");
        // R5: division by zero
        drive(4'h3, 1, 1, 64'h1234, 64'h0, 0, "R5 div zero");
        drive(4'h3, 0, 0, 64'hFFFF, 64'h3, 32'h0, "R5 div zero imm");
        // R6: unsigned division and modulo
        drive(4'h3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, "R6 div by -1 imm");
        drive(4'h3, 1, 0, 64'd100, 64'h0, 32'hFFFF_FFFE, "R6 div 100 by -2");
        drive(4'h9, 1, 0, 64'd7, 64'h0, 32'hFFFF_FFFF, "R6 mod 7 by -1");
        drive(4'h3, 0, 1, 64'h8000_0000, 64'h2, 0, "R6 div32 unsigned");
        drive(4'h9, 1, 1, 64'd1000, 64'd7, 0, "R6 mod 64");
        // R7: shift masking
        drive(4'h6, 0, 0, 64'h1, 64'h0, 32'd33, "R7 shl32 by 33");
        drive(4'h6, 1, 0, 64'h1, 64'h0, 32'd65, "R7 shl64 by 65");
        drive(4'h7, 1, 1, 64'h8000_0000_0000_0000, 64'd127, 0, "R7 shr64 by 127");
        drive(4'h7, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'd36, 0, "R7 shr32 by 36");
        // R8: arithmetic shift
        drive(4'hC, 1, 0, 64'h8000_0000_0000_0000, 64'h0, 32'd4, "R8 sra64");
        drive(4'hC, 0, 0, 64'h0000_0000_8000_0000, 64'h0, 32'd4, "R8 sra32");
        drive(4'hC, 1, 0, 64'h4000_0000_0000_0000, 64'h0, 32'd8, "R8 sra64 positive");
        // R9: byte order conversion
        drive(4'hD, 1, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R9 le16");
        drive(4'hD, 0, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R9 le32");
        drive(4'hD, 1, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R9 le64");
        drive(4'hD, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R9 be16");
        drive(4'hD, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R9 be32");
        drive(4'hD, 0, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R9 be64 narrow mode");
        // R10: invalid swap width
        drive(4'hD, 1, 1, 64'h1122_3344_5566_7788, 64'h0, 32'd8, "R10 width 8");
        drive(4'hD, 1, 0, 64'h1122_3344_5566_7788, 64'h0, 32'd48, "R10 width 48");
        // R11: no write for idle and unassigned codes
        idle("R11 idle");
        drive(4'hE, 1, 1, 64'h5, 64'h6, 0, "R11 code E");
        drive(4'hF, 0, 0, 64'h5, 64'h6, 32'h7, "R11 code F");
        // R13: operation right after gaps, then back-to-back
        drive(4'h0, 1, 1, 64'd40, 64'd2, 0, "R13 after gap");
        drive(4'h1, 1, 1, 64'd40, 64'd2, 0, "R13 next cycle");
        idle("R13 trailing idle");

        @(negedge clk);
        in_valid = 1'b0;
        while (q_we.size() > 0) @(negedge clk);
        stim_done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule